// File: doc/BRIEF.md
# Partition Freeze State Table

This block keeps the error-isolation state for every partition behind a host bridge. Each partition number has an entry with two flags. One flag blocks memory-mapped traffic. The other blocks DMA and interrupt-message traffic. A freeze event raises both flags of an entry at the same time. Software clears each flag on its own, through a separate clear port.

The same table also judges traffic. For each access the block receives a partition number and an access kind. One cycle later it returns a verdict: pass, drop, or all-ones. A write or interrupt message to a frozen partition is dropped. A read from a frozen partition completes with all-ones data.

Each partition can be given one companion partition. When a freeze comes from an error message, the companion is frozen in the same cycle. Freezes from any other source never spread.

Top module: `part_freeze_table`

## Requirements
- R1: After reset every entry is unfrozen, no companion link is enabled, and `res_valid` is 0.
- R2: A freeze event on partition p sets both flags of p on the next clock edge. Accesses presented from the following cycle onward see p as frozen.
- R3: A clear with `clr_mmio`=1 clears only the memory-mapped flag of the addressed partition and leaves its DMA flag unchanged.
- R4: A clear with `clr_dma`=1 clears only the DMA flag of the addressed partition and leaves its memory-mapped flag unchanged.
- R5: A read to a frozen partition (kind 0 memory-mapped read, kind 2 DMA read) gets verdict 2, meaning all-ones data.
- R6: A write to a frozen partition (kind 1 memory-mapped write, kind 3 DMA write) gets verdict 1, meaning drop.
- R7: An interrupt message (kind 4) from a partition whose DMA flag is set gets verdict 1, meaning blocked.
- R8: Kinds 0 and 1 are gated only by the memory-mapped flag. Kinds 2, 3 and 4 are gated only by the DMA flag. Reserved kinds 5 to 7 always get verdict 0.
- R9: A freeze with `frz_errmsg`=1 also freezes the configured companion when that companion link is enabled. A freeze with `frz_errmsg`=0, or one whose link is disabled, leaves the companion untouched.
- R10: When a freeze (direct or cascaded) and a clear address the same entry in the same cycle, the entry ends up frozen.
- R11: An access presented with `acc_valid` in cycle t produces `res_valid`=1 and its verdict in cycle t+1. The verdict is judged on the table as it stood in cycle t, before any update in that same cycle. An unfrozen target gets verdict 0, meaning pass.
- R12: A configuration write sets the companion number and the link enable of the addressed partition. Freeze events from the following cycle onward use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frz_valid | input | 1 | Freeze event strobe |
| frz_part | input | PW | Partition to freeze |
| frz_errmsg | input | 1 | Freeze was caused by an error message (enables cascading) |
| clr_valid | input | 1 | Software clear strobe |
| clr_part | input | PW | Partition to clear |
| clr_mmio | input | 1 | Clear the memory-mapped flag |
| clr_dma | input | 1 | Clear the DMA flag |
| cfg_valid | input | 1 | Companion configuration write strobe |
| cfg_part | input | PW | Partition whose companion link is written |
| cfg_comp | input | PW | Companion partition number |
| cfg_en | input | 1 | Companion link enable |
| acc_valid | input | 1 | Access to be judged |
| acc_part | input | PW | Partition targeted by the access |
| acc_kind | input | 3 | 0 mm read, 1 mm write, 2 DMA read, 3 DMA write, 4 interrupt message, 5-7 reserved |
| res_valid | output | 1 | Verdict valid, one cycle after `acc_valid` |
| res_verdict | output | 2 | 0 pass, 1 drop, 2 all-ones |

## Verification
The cases most likely to break are updates and judgments that land in the same cycle. One case is a freeze and a software clear on the same entry, including a clear on the companion that an error-message freeze reaches in that cycle. The other case is an access to a partition that is being frozen in that very cycle. The bench drives these together on one clock edge. It predicts from its own model that the set survives and that the access is judged on the earlier table state. A long mixed run then lets the scoreboard compare every verdict against that model.

// File: rtl/part_freeze_table.sv
module part_freeze_table #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frz_valid,
  input  logic [PW-1:0] frz_part,
  input  logic          frz_errmsg,
  input  logic          clr_valid,
  input  logic [PW-1:0] clr_part,
  input  logic          clr_mmio,
  input  logic          clr_dma,
  input  logic          cfg_valid,
  input  logic [PW-1:0] cfg_part,
  input  logic [PW-1:0] cfg_comp,
  input  logic          cfg_en,
  input  logic          acc_valid,
  input  logic [PW-1:0] acc_part,
  input  logic [2:0]    acc_kind,
  output logic          res_valid,
  output logic [1:0]    res_verdict
);
  localparam int NPART = 1 << PW;
  localparam logic [1:0] V_PASS = 2'd0, V_DROP = 2'd1, V_ONES = 2'd2;

  logic [NPART-1:0] mm_frz, dma_frz, comp_en;
  logic [PW-1:0]    comp_id [NPART];
  logic [NPART-1:0] set_vec, clr_m, clr_d;
  logic             casc;
  logic [PW-1:0]    casc_id;
  logic             gate, is_read;
  logic [1:0]       verdict;

  assign casc    = frz_valid && frz_errmsg && comp_en[frz_part];
  assign casc_id = comp_id[frz_part];

  always_comb begin
    set_vec = '0;
    clr_m   = '0;
    clr_d   = '0;
    if (frz_valid) set_vec[frz_part] = 1'b1;
    if (casc)      set_vec[casc_id]  = 1'b1;
    if (clr_valid) begin
      clr_m[clr_part] = clr_mmio;
      clr_d[clr_part] = clr_dma;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mm_frz  <= '0;
      dma_frz <= '0;
    end else begin
      mm_frz  <= set_vec | (mm_frz  & ~clr_m);
      dma_frz <= set_vec | (dma_frz & ~clr_d);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) comp_en <= '0;
    else if (cfg_valid) comp_en[cfg_part] <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (cfg_valid) comp_id[cfg_part] <= cfg_comp;
  end

  always_comb begin
    if (acc_kind <= 3'd1)      gate = mm_frz[acc_part];
    else if (acc_kind <= 3'd4) gate = dma_frz[acc_part];
    else                       gate = 1'b0;
  end

  assign is_read = (acc_kind == 3'd0) || (acc_kind == 3'd2);
  assign verdict = !gate ? V_PASS : (is_read ? V_ONES : V_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_verdict <= V_PASS;
    end else begin
      res_valid   <= acc_valid;
      res_verdict <= acc_valid ? verdict : V_PASS;
    end
  end

  p_freeze_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frz_valid |=> mm_frz[$past(frz_part)] && dma_frz[$past(frz_part)]);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_valid && clr_valid && clr_part == frz_part) |=>
      mm_frz[$past(clr_part)] && dma_frz[$past(clr_part)]);

  p_cascade_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_valid && frz_errmsg && comp_en[frz_part]) |=>
      mm_frz[$past(comp_id[frz_part])] && dma_frz[$past(comp_id[frz_part])]);

  p_clear_mm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mmio && !set_vec[clr_part]) |=> !mm_frz[$past(clr_part)]);

  p_clear_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_dma && !set_vec[clr_part]) |=> !dma_frz[$past(clr_part)]);

  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  p_write_never_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(acc_kind == 3'd0 || acc_kind == 3'd2)) |=> res_verdict != V_ONES);

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_verdict != 2'd3);
endmodule

// File: tb/part_freeze_table_bench.sv
`timescale 1ns/1ps
module part_freeze_table_bench;
  localparam int PW = 8;
  localparam int N  = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frz_valid = 0, frz_errmsg = 0, clr_valid = 0, clr_mmio = 0, clr_dma = 0;
  logic cfg_valid = 0, cfg_en = 0, acc_valid = 0;
  logic [PW-1:0] frz_part = 0, clr_part = 0, cfg_part = 0, cfg_comp = 0, acc_part = 0;
  logic [2:0] acc_kind = 0;
  logic res_valid;
  logic [1:0] res_verdict;

  always #2 clk = ~clk;

  part_freeze_table #(.PW(PW)) u_part_freeze_table (
    .clk(clk), .rst_n(rst_n),
    .frz_valid(frz_valid), .frz_part(frz_part), .frz_errmsg(frz_errmsg),
    .clr_valid(clr_valid), .clr_part(clr_part), .clr_mmio(clr_mmio), .clr_dma(clr_dma),
    .cfg_valid(cfg_valid), .cfg_part(cfg_part), .cfg_comp(cfg_comp), .cfg_en(cfg_en),
    .acc_valid(acc_valid), .acc_part(acc_part), .acc_kind(acc_kind),
    .res_valid(res_valid), .res_verdict(res_verdict)
  );

  bit mm [N];
  bit dm [N];
  bit cen [N];
  int cid [N];
  int exp_q [$];
  string tag_q [$];
  string cur_tag = "R11";
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int predict(int p, int k);
    bit g;
    if (k <= 1)      g = mm[p];
    else if (k <= 4) g = dm[p];
    else             g = 0;
    if (!g) return 0;
    return (k == 0 || k == 2) ? 2 : 1;
  endfunction

  task automatic tick();
    bit c;
    if (acc_valid) begin
      exp_q.push_back(predict(int'(acc_part), int'(acc_kind)));
      tag_q.push_back(cur_tag);
    end
    c = frz_valid && frz_errmsg && cen[frz_part];
    if (clr_valid) begin
      if (clr_mmio) mm[clr_part] = 0;
      if (clr_dma)  dm[clr_part] = 0;
    end
    if (frz_valid) begin mm[frz_part] = 1; dm[frz_part] = 1; end
    if (c) begin mm[cid[frz_part]] = 1; dm[cid[frz_part]] = 1; end
    if (cfg_valid) begin cen[cfg_part] = cfg_en; cid[cfg_part] = int'(cfg_comp); end
    @(negedge clk);
    frz_valid = 0; clr_valid = 0; cfg_valid = 0; acc_valid = 0;
  endtask

  task automatic acc(int p, int k, string t);
    acc_valid = 1; acc_part = PW'(p); acc_kind = 3'(k); cur_tag = t;
  endtask
  task automatic frz(int p, bit e);
    frz_valid = 1; frz_part = PW'(p); frz_errmsg = e;
  endtask
  task automatic clr(int p, bit m, bit d);
    clr_valid = 1; clr_part = PW'(p); clr_mmio = m; clr_dma = d;
  endtask
  task automatic cfg(int p, int c, bit e);
    cfg_valid = 1; cfg_part = PW'(p); cfg_comp = PW'(c); cfg_en = e;
  endtask
  task automatic acc_all(int p, string t);
    for (int k = 0; k < 8; k++) begin acc(p, k, t); tick(); end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected result: actual=%0d expected=none", res_verdict);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(res_verdict) != e) begin
          n_bad++;
          $display("FAIL %s verdict: actual=%0d expected=%0d", t, res_verdict, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mm[i] = 0; dm[i] = 0; cen[i] = 0; cid[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset res_valid: actual=%0d expected=0", res_valid);
    end
    // R1 / R11: unfrozen partitions pass, including both ends of the range
    acc_all(7, "R1");
    acc_all(0, "R11");
    acc_all(255, "R11");
    // R11: access in the same cycle as its freeze sees the old state
    frz(5, 0); acc(5, 0, "R11"); tick();
    // R2, R5, R6, R7
    acc(5, 0, "R5"); tick();
    acc(5, 2, "R5"); tick();
    acc(5, 1, "R6"); tick();
    acc(5, 3, "R6"); tick();
    acc(5, 4, "R7"); tick();
    acc_all(5, "R8");
    // R3: clear memory-mapped flag only
    clr(5, 1, 0); tick();
    acc(5, 0, "R3"); tick();
    acc(5, 2, "R3"); tick();
    acc(5, 4, "R8"); tick();
    // R4: clear DMA flag only
    frz(9, 0); tick();
    clr(9, 0, 1); tick();
    acc(9, 3, "R4"); tick();
    acc(9, 4, "R4"); tick();
    acc(9, 1, "R4"); tick();
    // R9 / R12: companion link
    cfg(20, 30, 1); tick();
    frz(20, 0); tick();
    acc_all(30, "R9");
    clr(20, 1, 1); tick();
    frz(20, 1); tick();
    acc(30, 0, "R9"); tick();
    acc(30, 3, "R9"); tick();
    cfg(40, 41, 0); tick();
    frz(40, 1); tick();
    acc_all(41, "R9");
    cfg(40, 42, 1); frz(40, 1); tick();
    acc(42, 0, "R12"); tick();
    frz(40, 1); tick();
    acc(42, 0, "R12"); tick();
    // R10: set beats clear, direct and cascaded
    frz(50, 0); clr(50, 1, 1); tick();
    acc(50, 0, "R10"); tick();
    acc(50, 2, "R10"); tick();
    clr(30, 1, 1); tick();
    acc(30, 0, "R3"); tick();
    frz(20, 1); clr(30, 1, 1); tick();
    acc(30, 0, "R10"); tick();
    acc(30, 4, "R10"); tick();
    frz(255, 0); tick();
    acc(255, 0, "R5"); tick();
    // mixed traffic, judged by the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) frz($urandom_range(0, 31), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) clr($urandom_range(0, 31), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 15) == 0) cfg($urandom_range(0, 31), $urandom_range(0, 31), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) != 0) acc($urandom_range(0, 31), $urandom_range(0, 7), "R8");
      tick();
    end
    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 missing results: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule